// File: doc/BRIEF.md
# Serial SAR Converter Interface Sequencer

This block is the digital control and serial-output half of a low-power successive-approximation converter. A host frames each conversion with an active-low select line and supplies a serial clock. The same serial clock paces the conversion. A parallel sample word stands in for the analog front end. When select falls, the block leaves power-down and starts tracking. On the third serial-clock falling edge it switches to hold and latches the sample. It then shifts out a fixed-length frame: four zero bits, followed by the result in straight binary, most significant bit first.

The frame ends by itself. On its last falling edge the data line is released and the block powers down again. Raising select before that point abandons the conversion at once. All pins are sampled in the block's own clock domain. Each serial-clock or select transition takes effect on the outputs one clock later.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, `pd_o` is 1, and `sdata_oe`, `sdata_o`, `track_o` and `held_o` are 0.
- R2: One clock after `cs_n` is seen falling, `sdata_oe` is 1, `sdata_o` is 0 (first leading zero), `track_o` is 1 and `pd_o` is 0.
- R3: The frame is `RES`+4 bits long. Bit 0 comes from the select edge. Bit k (k≥1) is launched on serial falling edge k. Bits 0–3 are 0, and bits 4 to `RES`+3 carry the captured word, MSB first, in straight binary.
- R4: On the third serial falling edge, `track_o` goes to 0 and the sample word is captured. Later changes of `sample` do not alter the shifted result.
- R5: `held_o` is 1 from the third serial falling edge until the frame ends or is aborted, and 0 at all other times.
- R6: The last data bit stays on the line until the final falling edge (`RES`+4). On that edge `sdata_oe` goes to 0 and `pd_o` goes to 1.
- R7: If `cs_n` rises before the final edge, then one clock later `sdata_oe`, `track_o` and `held_o` are 0 and `pd_o` is 1.
- R8: Serial clock edges have no effect while `cs_n` is high. The block stays powered down with the line released.
- R9: Serial falling edges after the frame has ended, with `cs_n` still low, do not drive the line or change any output.
- R10: `sdata_o` is 0 whenever `sdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its fall starts a frame, its rise aborts it |
| sclk | input | 1 | Serial clock; its falling edges advance the frame |
| sample | input | RES | Parallel conversion word, captured at the hold edge |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Output enable of the serial data line (0 = high impedance) |
| track_o | output | 1 | Track/hold control, 1 = track, 0 = hold |
| pd_o | output | 1 | Power-down status |
| held_o | output | 1 | High while a captured sample is being shifted |

## Verification
The assertions check the relations that hold on every clock. These are: the line is quiet whenever it is released, power-down and drive never overlap, the response to a select fall or rise is seen one clock later, and the hold flag shows only while the block is holding and powered. Several things only the bench scenarios can show. These are the exact bit order of the frame for several sample patterns, and the capture instant under a sample that changes mid-frame. They also include the frame length, aborts both before and after the hold edge, and serial edges that arrive after the frame has ended.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } seq_state_e;

    // number of zero bits that lead every frame
    localparam int LEAD_ZEROS = 4;
    // serial falling edge on which the track/hold goes to hold
    localparam int HOLD_EDGE  = 3;

    function automatic bit res_supported(input int res);
        return (res == 8) || (res == 10) || (res == 12);
    endfunction

    function automatic int frame_len(input int res);
        return res + LEAD_ZEROS;
    endfunction

endpackage

// File: rtl/sar_pin_edges.sv
module sar_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_fall
);

    typedef struct packed {
        logic cs;
        logic sck;
    } pin_hist_t;

    pin_hist_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.cs  = cs_n;
        hist_d.sck = sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{cs: 1'b1, sck: 1'b1};
        end else begin
            hist_q <= hist_d;
        end
    end

    assign cs_fall  = hist_q.cs & ~cs_n;
    assign cs_rise  = ~hist_q.cs & cs_n;
    // serial edges only count while the select is low
    assign sck_fall = hist_q.sck & ~sclk & ~cs_n;

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
    import sar_seq_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sck_fall,
    output logic capture,
    output logic ld_zero,
    output logic ld_data,
    output logic track_o,
    output logic pd_o,
    output logic oe_o,
    output logic held_o
);

    localparam int FRAME = frame_len(RES);
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_EDGE);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(LEAD_ZEROS);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             track;
        logic             pd;
        logic             oe;
        logic             held;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        capture = 1'b0;
        ld_zero = 1'b0;
        ld_data = 1'b0;
        cnt_inc = s_q.cnt + 1'b1;

        if (cs_rise) begin
            // abort or normal release: everything back to sleep
            s_d.state = ST_SLEEP;
            s_d.oe    = 1'b0;
            s_d.pd    = 1'b1;
            s_d.track = 1'b0;
            s_d.held  = 1'b0;
        end else if (cs_fall) begin
            s_d.state = ST_RUN;
            s_d.cnt   = '0;
            s_d.oe    = 1'b1;
            s_d.pd    = 1'b0;
            s_d.track = 1'b1;
            s_d.held  = 1'b0;
            ld_zero   = 1'b1;
        end else if (s_q.state == ST_RUN && sck_fall) begin
            s_d.cnt = cnt_inc;
            if (cnt_inc == CNT_LAST) begin
                s_d.state = ST_SPENT;
                s_d.oe    = 1'b0;
                s_d.pd    = 1'b1;
                s_d.held  = 1'b0;
            end else if (cnt_inc >= CNT_DATA) begin
                ld_data = 1'b1;
            end else begin
                ld_zero = 1'b1;
            end
            if (cnt_inc == CNT_HOLD) begin
                s_d.track = 1'b0;
                s_d.held  = 1'b1;
                capture   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_SLEEP, cnt: '0, track: 1'b0,
                     pd: 1'b1, oe: 1'b0, held: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign track_o = s_q.track;
    assign pd_o    = s_q.pd;
    assign oe_o    = s_q.oe;
    assign held_o  = s_q.held;

endmodule

// File: rtl/sar_result_shift.sv
module sar_result_shift #(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RES-1:0] sample,
    input  logic           capture,
    input  logic           ld_zero,
    input  logic           ld_data,
    output logic           bit_o
);

    typedef struct packed {
        logic [RES-1:0] word;
        logic           bit_v;
    } shift_regs_t;

    shift_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (capture) begin
            r_d.word = sample;
        end
        if (ld_zero) begin
            r_d.bit_v = 1'b0;
        end else if (ld_data) begin
            r_d.bit_v = r_q.word[RES-1];
            r_d.word  = {r_q.word[RES-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_o = r_q.bit_v;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic [RES-1:0] sample,
    output logic           sdata_o,
    output logic           sdata_oe,
    output logic           track_o,
    output logic           pd_o,
    output logic           held_o
);

    generate
        if (!res_supported(RES)) begin : g_bad_res
            $error("sar_serial_seq: RES must be 8, 10 or 12");
        end
    endgenerate

    logic cs_fall, cs_rise, sck_fall;
    logic capture, ld_zero, ld_data;
    logic oe, bit_v;

    sar_pin_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_fall (sck_fall)
    );

    sar_frame_seq #(.RES(RES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_fall (sck_fall),
        .capture  (capture),
        .ld_zero  (ld_zero),
        .ld_data  (ld_data),
        .track_o  (track_o),
        .pd_o     (pd_o),
        .oe_o     (oe),
        .held_o   (held_o)
    );

    sar_result_shift #(.RES(RES)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .capture (capture),
        .ld_zero (ld_zero),
        .ld_data (ld_data),
        .bit_o   (bit_v)
    );

    assign sdata_oe = oe;
    assign sdata_o  = oe & bit_v;

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdata_o,
    input logic sdata_oe,
    input logic track_o,
    input logic pd_o,
    input logic held_o
);

    // R10
    quiet_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe |-> !sdata_o);

    // R6
    pd_excludes_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> !sdata_oe);

    // R6
    release_means_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe) |-> pd_o);

    // R2
    start_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> (sdata_oe && track_o && !sdata_o && !pd_o));

    // R7
    abort_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (!sdata_oe && pd_o && !track_o && !held_o));

    // R8
    idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (pd_o && !sdata_oe && !track_o));

    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(track_o) && !pd_o) |-> held_o);

    // R5
    held_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_o |-> (!track_o && !pd_o && sdata_oe));

endmodule

bind sar_serial_seq sar_serial_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe),
    .track_o  (track_o),
    .pd_o     (pd_o),
    .held_o   (held_o)
);

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

    localparam int RES   = 12;
    localparam int FRAME = RES + 4;
    localparam int HOLD  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b1;
    logic [RES-1:0] sample = '0;
    logic           sdata_o, sdata_oe, track_o, pd_o, held_o;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    sar_serial_seq #(.RES(RES)) u_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .track_o(track_o),
        .pd_o(pd_o), .held_o(held_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model, evaluated on each rising edge
    bit m_run = 0, m_oe = 0, m_pd = 1, m_trk = 0, m_held = 0, m_bit = 0;
    bit m_pcs = 1, m_psck = 1;
    int m_cnt = 0;
    bit m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_oe = 0; m_pd = 1; m_trk = 0; m_held = 0; m_bit = 0;
            m_pcs = 1; m_psck = 1; m_cnt = 0; m_q.delete();
        end else begin
            if (!m_pcs && cs_n) begin
                m_run = 0; m_oe = 0; m_pd = 1; m_trk = 0; m_held = 0;
            end else if (m_pcs && !cs_n) begin
                m_run = 1; m_cnt = 0; m_oe = 1; m_bit = 0; m_pd = 0;
                m_trk = 1; m_held = 0;
            end else if (m_run && m_psck && !sclk) begin
                m_cnt++;
                if (m_cnt == HOLD) begin
                    m_trk = 0; m_held = 1; m_q.delete();
                    for (int i = RES - 1; i >= 0; i--) m_q.push_back(sample[i]);
                end
                if (m_cnt == FRAME) begin
                    m_run = 0; m_oe = 0; m_pd = 1; m_held = 0;
                end else if (m_cnt >= 4) begin
                    m_bit = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
                end else begin
                    m_bit = 0;
                end
            end
            m_pcs = cs_n; m_psck = sclk;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(sdata_oe == m_oe,   tag, "sdata_oe", sdata_oe, m_oe);
            chk(sdata_o == (m_oe & m_bit), tag, "sdata_o", sdata_o, m_oe & m_bit);
            chk(track_o == m_trk,   tag, "track_o", track_o, m_trk);
            chk(pd_o == m_pd,       tag, "pd_o", pd_o, m_pd);
            chk(held_o == m_held,   tag, "held_o", held_o, m_held);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sclk = 1'b0; wait_n(2);
        sclk = 1'b1; wait_n(2);
    endtask

    // runs n_edges serial falling edges after select falls; select stays low
    task automatic run_frame(input logic [RES-1:0] smp, input int n_edges,
                             input int change_after, output logic [FRAME-1:0] got);
        got = '0;
        sample = smp;
        cs_n = 1'b0; wait_n(2);
        chk(sdata_oe && !sdata_o && track_o && !pd_o, "R2", "start state",
            {sdata_oe, sdata_o, track_o, pd_o}, 4'b1010);
        for (int e = 1; e <= n_edges; e++) begin
            if (e <= FRAME) got[FRAME-e] = sdata_o;
            sclk = 1'b0; wait_n(2);
            if (e == HOLD)
                chk(held_o && !track_o, "R5", "hold edge", {held_o, track_o}, 2'b10);
            if (e == HOLD - 1)
                chk(!held_o && track_o, "R5", "before hold", {held_o, track_o}, 2'b01);
            if (e == change_after) sample = ~smp;
            sclk = 1'b1; wait_n(2);
        end
    endtask

    task automatic end_select();
        cs_n = 1'b1; wait_n(3);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [FRAME-1:0] got;
        logic [RES-1:0] pats [5];
        pats[0] = 12'hA5C; pats[1] = 12'h000; pats[2] = 12'hFFF;
        pats[3] = 12'h001; pats[4] = 12'h800;

        wait_n(3);
        chk(pd_o && !sdata_oe && !sdata_o && !track_o && !held_o, "R1", "reset state",
            {pd_o, sdata_oe, sdata_o, track_o, held_o}, 5'b10000);
        rst_n = 1'b1; wait_n(2);

        tag = "R8";
        for (int i = 0; i < 4; i++) sck_pulse();
        chk(pd_o && !sdata_oe, "R8", "edges with select high", {pd_o, sdata_oe}, 2'b10);

        tag = "R3";
        foreach (pats[p]) begin
            run_frame(pats[p], FRAME, -1, got);
            chk(got == {4'b0000, pats[p]}, "R3", "frame word", got, {4'b0000, pats[p]});
            chk(!sdata_oe && pd_o, "R6", "auto power-down", {sdata_oe, pd_o}, 2'b01);
            end_select();
        end

        tag = "R4";
        run_frame(12'h3C6, FRAME, HOLD, got);
        chk(got == {4'b0000, 12'h3C6}, "R4", "captured word", got, {4'b0000, 12'h3C6});
        tag = "R9";
        for (int i = 0; i < 3; i++) sck_pulse();
        chk(!sdata_oe && !sdata_o && pd_o && !held_o, "R9", "edges after frame",
            {sdata_oe, sdata_o, pd_o, held_o}, 4'b0010);
        end_select();

        tag = "R7";
        run_frame(12'h5A5, 6, -1, got);
        cs_n = 1'b1; wait_n(2);
        chk(!sdata_oe && pd_o && !held_o && !track_o, "R7", "abort after hold",
            {sdata_oe, pd_o, held_o, track_o}, 4'b0100);
        wait_n(2);
        run_frame(12'h777, 1, -1, got);
        cs_n = 1'b1; wait_n(2);
        chk(!sdata_oe && pd_o && !track_o, "R7", "abort while tracking",
            {sdata_oe, pd_o, track_o}, 3'b010);
        wait_n(2);

        tag = "R10";
        run_frame(12'hFFE, FRAME - 1, -1, got);
        chk(sdata_oe && sdata_o == 1'b0, "R6", "last bit held before final edge",
            {sdata_oe, sdata_o}, 2'b10);
        sck_pulse();
        chk(!sdata_oe && !sdata_o, "R10", "released line quiet", {sdata_oe, sdata_o}, 2'b00);
        end_select();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule